// File: doc/BRIEF.md
# Three-Channel Interval Timer with Alternating Limits and Chained Prescale

This block holds three 16-bit up-counting timers behind a small register bus. Each timer counts from zero up to a programmed limit, then returns to zero on its next count event and emits a one-cycle terminal pulse. The pulse can also raise an interrupt request. Timers 0 and 1 hold two limit registers, A and B. In alternating mode they use A and B in turn, and a status bit shows which limit is active. Timer 2 holds only limit A. Its terminal pulse can replace the shared count strobe as the step source of timer 0 or timer 1, which makes timer 2 an on-chip prescaler for them.

Software loads the count register, normally with zero, before it sets the enable bit. When timer 2 prescales another timer, software enables timer 2 last so that the first prescaled period has a known length. A register write to a timer wins over a count event that falls in the same cycle.

Top module: `tri_timer_unit`

## Requirements
- R1: After reset, every address reads zero and no terminal pulse or interrupt request is active.
- R2: Timer t occupies addresses 4t+0 (count), 4t+1 (limit A), 4t+2 (limit B) and 4t+3 (control). Reads are combinational from rd_addr, and addresses 12 to 15 read zero. Control bits: 0 enable, 1 continuous, 2 alternate, 3 prescale select, 4 interrupt enable, 5 sticky terminal flag, 6 limit B active (read-only). Timer 2 limit B always reads zero and ignores writes. Timer 2 control bits 2 and 3 always read zero.
- R3: An enabled timer whose step source is high, and whose count is not at the active limit, adds one to its count.
- R4: A step event while the count equals the active limit sets the count to zero. In that same cycle, the timer's max_pulse bit is high for exactly that cycle, and its irq bit is high if interrupt enable is set.
- R5: The sticky flag (bit 5) sets on a terminal pulse. A control write with bit 5 at 0 clears it, and a control write with bit 5 at 1 leaves it unchanged.
- R6: With continuous (bit 1) at 0, the timer clears its own enable bit on its terminal pulse. With continuous at 1, it stays enabled.
- R7: With alternate (bit 2) set, the timer starts on limit A and switches to the other limit on each terminal pulse. Bit 6 reads 1 while limit B is active. Any control write makes limit A active again.
- R8: With prescale select (bit 3) set, timer 0 or 1 steps only on timer 2's terminal pulse and ignores the shared strobe. Otherwise it steps on each cycle with tick high.
- R9: A write to any register of a timer in a cycle where that timer would step cancels the step: there is no increment and no pulse, and the written value takes effect.
- R10: A timer with its enable bit clear keeps its count and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data for rd_addr |
| max_pulse | output | 3 | Per-timer terminal pulse |
| irq | output | 3 | Per-timer interrupt request pulse |

## Verification
On every cycle the assertions check the local rules of each timer. A terminal pulse is followed by a zero count, and a non-limit step adds exactly one. A single-shot timer drops its enable after its pulse, the active limit switches on each pulse in alternating mode, the sticky flag holds until a control write, a count write lands as written, and an idle timer keeps its count. The bench's scenarios are what show behaviour across timers and across the bus. These include the prescale chain and the order in which the timers are enabled, the cancellation of a step by a write to a limit register, the dropped timer 2 fields, and the full address map, all compared against a behavioural model on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_EN   = 0;
  localparam int CTL_CONT = 1;
  localparam int CTL_ALT  = 2;
  localparam int CTL_PSEL = 3;
  localparam int CTL_IE   = 4;
  localparam int CTL_FLAG = 5;
  localparam int CTL_SELB = 6;

  typedef enum logic [1:0] {
    OFS_COUNT = 2'd0,
    OFS_LIMA  = 2'd1,
    OFS_LIMB  = 2'd2,
    OFS_CTL   = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W     = 16,
  parameter bit HAS_B = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_stb,
  input  logic         wr_cnt,
  input  logic         wr_ca,
  input  logic         wr_cb,
  input  logic         wr_ctl,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] ca_q,
  output logic [W-1:0] cb_q,
  output logic [W-1:0] ctl_rd,
  output logic         psel_o,
  output logic         max_o,
  output logic         irq_o
);
  import tmr_pkg::*;

  logic en_q, cont_q, alt_q, psel_q, ie_q, flag_q, sel_q;
  logic any_wr, step_ev, at_lim;
  logic [W-1:0] lim_act;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic hit);
    return hit ? '0 : c + W'(1);
  endfunction

  assign any_wr  = wr_cnt | wr_ca | wr_cb | wr_ctl;
  assign lim_act = sel_q ? cb_q : ca_q;
  assign at_lim  = (cnt_q == lim_act);
  assign step_ev = en_q & src_stb & ~any_wr;
  assign max_o   = step_ev & at_lim;
  assign irq_o   = max_o & ie_q;
  assign psel_o  = psel_q;

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_EN]   = en_q;
    ctl_rd[CTL_CONT] = cont_q;
    ctl_rd[CTL_ALT]  = alt_q;
    ctl_rd[CTL_PSEL] = psel_q;
    ctl_rd[CTL_IE]   = ie_q;
    ctl_rd[CTL_FLAG] = flag_q;
    ctl_rd[CTL_SELB] = sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ca_q  <= '0;
    end else begin
      if (wr_cnt)       cnt_q <= wr_data;
      else if (step_ev) cnt_q <= next_count(cnt_q, at_lim);
      if (wr_ca)        ca_q  <= wr_data;
    end
  end

  generate
    if (HAS_B) begin : g_limb
      always_ff @(posedge clk) begin
        if (!rst_n)     cb_q <= '0;
        else if (wr_cb) cb_q <= wr_data;
      end
    end else begin : g_nolimb
      assign cb_q = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; cont_q <= 1'b0; alt_q <= 1'b0; psel_q <= 1'b0;
      ie_q <= 1'b0; flag_q <= 1'b0; sel_q <= 1'b0;
    end else if (wr_ctl) begin
      en_q   <= wr_data[CTL_EN];
      cont_q <= wr_data[CTL_CONT];
      alt_q  <= HAS_B & wr_data[CTL_ALT];
      psel_q <= HAS_B & wr_data[CTL_PSEL];
      ie_q   <= wr_data[CTL_IE];
      flag_q <= flag_q & wr_data[CTL_FLAG];
      sel_q  <= 1'b0;
    end else if (max_o) begin
      flag_q <= 1'b1;
      if (alt_q)   sel_q <= ~sel_q;
      if (!cont_q) en_q  <= 1'b0;
    end
  end

  a_r3_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !at_lim) |=> (cnt_q == $past(cnt_q) + W'(1)));
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    max_o |=> (cnt_q == '0));
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_ctl) |=> flag_q);
  a_r6_single_shot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (max_o && !cont_q) |=> !en_q);
  a_r7_alt_switches: assert property (@(posedge clk) disable iff (!rst_n)
    (max_o && alt_q) |=> (sel_q != $past(sel_q)));
  a_r7_single_uses_a: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_q |-> !sel_q);
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data)));
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: rtl/tri_timer_unit.sv
module tri_timer_unit #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [2:0]    max_pulse,
  output logic [2:0]    irq
);
  import tmr_pkg::*;

  localparam int NT  = 3;
  localparam int SW  = AW - 2;

  logic [W-1:0] cnt_v [NT];
  logic [W-1:0] ca_v  [NT];
  logic [W-1:0] cb_v  [NT];
  logic [W-1:0] ctl_v [NT];
  logic [1:0]   mp01, irq01, psel01;
  logic         mp2, irq2, psel2;
  logic [NT-1:0] hit_t;
  logic [1:0]   wofs;

  assign wofs = wr_addr[1:0];

  for (genvar t = 0; t < NT; t++) begin : g_dec
    assign hit_t[t] = wr_en && (wr_addr[AW-1:2] == SW'(t));
  end

  tmr_core #(.W(W), .HAS_B(1'b0)) u_t2 (
    .clk(clk), .rst_n(rst_n), .src_stb(tick),
    .wr_cnt(hit_t[2] && wofs == OFS_COUNT),
    .wr_ca (hit_t[2] && wofs == OFS_LIMA),
    .wr_cb (hit_t[2] && wofs == OFS_LIMB),
    .wr_ctl(hit_t[2] && wofs == OFS_CTL),
    .wr_data(wr_data),
    .cnt_q(cnt_v[2]), .ca_q(ca_v[2]), .cb_q(cb_v[2]), .ctl_rd(ctl_v[2]),
    .psel_o(psel2), .max_o(mp2), .irq_o(irq2)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ab
    logic src;
    assign src = psel01[g] ? mp2 : tick;
    tmr_core #(.W(W), .HAS_B(1'b1)) u_t (
      .clk(clk), .rst_n(rst_n), .src_stb(src),
      .wr_cnt(hit_t[g] && wofs == OFS_COUNT),
      .wr_ca (hit_t[g] && wofs == OFS_LIMA),
      .wr_cb (hit_t[g] && wofs == OFS_LIMB),
      .wr_ctl(hit_t[g] && wofs == OFS_CTL),
      .wr_data(wr_data),
      .cnt_q(cnt_v[g]), .ca_q(ca_v[g]), .cb_q(cb_v[g]), .ctl_rd(ctl_v[g]),
      .psel_o(psel01[g]), .max_o(mp01[g]), .irq_o(irq01[g])
    );
  end

  assign max_pulse = {mp2, mp01};
  assign irq       = {irq2, irq01};

  always_comb begin
    rd_data = '0;
    for (int t = 0; t < NT; t++) begin
      if (rd_addr[AW-1:2] == SW'(t)) begin
        case (rd_addr[1:0])
          OFS_COUNT: rd_data = cnt_v[t];
          OFS_LIMA:  rd_data = ca_v[t];
          OFS_LIMB:  rd_data = cb_v[t];
          default:   rd_data = ctl_v[t];
        endcase
      end
    end
  end

  a_r8_t2_never_prescaled: assert property (@(posedge clk) disable iff (!rst_n)
    !psel2);
  a_r4_irq_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~max_pulse) == 3'b000));
endmodule

// File: tb/test_tri_timer_unit.sv
module test_tri_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  max_pulse, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt[3], m_ca[3], m_cb[3];
  bit m_en[3], m_cont[3], m_alt[3], m_ps[3], m_ie[3], m_flag[3], m_sel[3];
  bit m_mc[3];

  tri_timer_unit i_tri_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .max_pulse(max_pulse), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    int t = a / 4;
    if (t > 2) return 0;
    case (a % 4)
      0: return m_cnt[t];
      1: return m_ca[t];
      2: return m_cb[t];
      default: return m_en[t] + 2*m_cont[t] + 4*m_alt[t] + 8*m_ps[t]
                      + 16*m_ie[t] + 32*m_flag[t] + 64*m_sel[t];
    endcase
  endfunction

  function automatic bit wr_to(input int t);
    return wr_en && (wr_addr / 4 == t);
  endfunction

  task automatic model_reset();
    for (int t = 0; t < 3; t++) begin
      m_cnt[t] = 0; m_ca[t] = 0; m_cb[t] = 0; m_en[t] = 0; m_cont[t] = 0;
      m_alt[t] = 0; m_ps[t] = 0; m_ie[t] = 0; m_flag[t] = 0; m_sel[t] = 0;
    end
  endtask

  // one clock: inputs already applied after the falling edge
  task automatic cycle();
    bit src;
    int lim, t, d;
    #1;
    for (int k = 2; k >= 0; k--) begin
      src = (k < 2 && m_ps[k]) ? m_mc[2] : tick;
      lim = m_sel[k] ? m_cb[k] : m_ca[k];
      m_mc[k] = m_en[k] && src && !wr_to(k) && (m_cnt[k] == lim);
    end
    check("R4 max_pulse", max_pulse, {m_mc[2], m_mc[1], m_mc[0]});
    check("R4 irq", irq, {m_mc[2] & m_ie[2], m_mc[1] & m_ie[1], m_mc[0] & m_ie[0]});
    check("R2 rd_data", rd_data, model_read(rd_addr));
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      src = (k < 2 && m_ps[k]) ? m_mc[2] : tick;
      if (!wr_to(k) && m_en[k] && src) begin
        if (m_mc[k]) begin
          m_cnt[k] = 0; m_flag[k] = 1;
          if (m_alt[k]) m_sel[k] = !m_sel[k];
          if (!m_cont[k]) m_en[k] = 0;
        end else m_cnt[k] = (m_cnt[k] + 1) % 65536;
      end
    end
    if (wr_en && wr_addr < 12) begin
      t = wr_addr / 4; d = wr_data;
      case (wr_addr % 4)
        0: m_cnt[t] = d;
        1: m_ca[t] = d;
        2: if (t < 2) m_cb[t] = d;
        default: begin
          m_en[t] = d[0]; m_cont[t] = d[1];
          m_alt[t] = (t < 2) && d[2]; m_ps[t] = (t < 2) && d[3];
          m_ie[t] = d[4]; m_flag[t] = m_flag[t] && d[5]; m_sel[t] = 0;
        end
      endcase
    end
    @(negedge clk);
  endtask

  task automatic drive(input bit tk, input bit we, input int wa, input int wd, input int ra);
    tick = tk; wr_en = we; wr_addr = 4'(wa); wr_data = 16'(wd); rd_addr = 4'(ra);
    cycle();
  endtask

  task automatic wr(input int a, input int d);
    drive(0, 1, a, d, 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, i % 16);
  endtask

  task automatic expect_rd(input int a, input int exp, input string tag);
    tick = 0; wr_en = 0; rd_addr = 4'(a);
    #1;
    check(tag, rd_data, exp);
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 16; a++) expect_rd(a, 0, "R1 reset read");

    // R3/R4/R5: timer 0 continuous, limit 3, interrupt on
    wr(0, 0); wr(1, 3); wr(3, 16'h13);
    run(2);
    expect_rd(0, 2, "R3 count after two steps");
    run(2);
    expect_rd(0, 0, "R4 wrapped to zero");
    expect_rd(3, 16'h33, "R5 flag set");
    wr(3, 16'h33);
    expect_rd(3, 16'h33, "R5 write one keeps flag");
    wr(3, 16'h13);
    expect_rd(3, 16'h13, "R5 write zero clears flag");

    // R10: disabled timer holds
    run(2);
    wr(3, 0);
    run(5);
    expect_rd(0, 2, "R10 disabled holds count");

    // R6: single-shot timer 1
    wr(4, 0); wr(5, 2); wr(7, 16'h11);
    run(3);
    expect_rd(7, 16'h30, "R6 single shot cleared enable");
    run(3);
    expect_rd(4, 0, "R6 stays stopped");
    wr(4, 0); wr(7, 16'h13);
    run(6);
    expect_rd(7, 16'h33, "R6 continuous stays enabled");
    wr(7, 0);

    // R7: alternating limits on timer 0
    wr(0, 0); wr(1, 1); wr(2, 2); wr(3, 16'h07);
    run(2);
    expect_rd(3, 16'h67, "R7 limit B active");
    run(3);
    expect_rd(3, 16'h27, "R7 back to limit A");
    run(2);
    wr(3, 16'h07);
    expect_rd(3, 16'h07, "R7 control write restores A");
    wr(3, 0);

    // R8: timer 1 prescaled by timer 2, timer 2 enabled last
    wr(4, 0); wr(5, 100); wr(7, 16'h0B);
    wr(8, 0); wr(9, 2); wr(11, 16'h03);
    run(9);
    expect_rd(4, 3, "R8 prescaled count");

    // R2: timer 2 drops limit B and mode bits
    wr(11, 0);
    wr(10, 16'h1234);
    expect_rd(10, 0, "R2 timer2 limit B ignored");
    wr(11, 16'h0E);
    expect_rd(11, 16'h02, "R2 timer2 mode bits dropped");
    wr(11, 0);
    expect_rd(13, 0, "R2 unused address");

    // R9: write beats step
    wr(0, 0); wr(1, 100); wr(3, 16'h03);
    run(3);
    drive(1, 1, 0, 50, 0);
    expect_rd(0, 50, "R9 count write beats step");
    wr(1, 50);
    drive(1, 1, 2, 7, 0);
    expect_rd(0, 50, "R9 limit write cancels wrap");
    run(1);
    expect_rd(0, 0, "R9 wrap after write cycle");

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom % 8) == 0;
      int a = $urandom % 16;
      int d = (a % 4 == 3) ? ($urandom % 128) : ($urandom % 8);
      drive(1'($urandom % 4 != 0), we, a, d, $urandom % 16);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule